// File: doc/BRIEF.md
# Shared Memory Arbiter with Private Window

This block lets three masters share one single-port synchronous RAM: the local processor, the local network DMA engine and a master on the external system bus. Each master has its own request, write-enable, address and write-data inputs and its own acknowledge. Read data comes back on one shared return bus. When several masters ask at once, a fixed priority picks the winner. A won access takes exactly two cycles: a command cycle that drives the RAM, then an acknowledge cycle that returns the data. No other master is served until that access has finished.

A size register, written from the local side, marks the bottom of the RAM as private. The window grows in quarter-of-memory steps, so a larger RAM gives larger steps. An external access that falls inside the window is never issued to the RAM and never acknowledged. It waits until the bus watchdog notices the silence and raises a one-cycle timeout interrupt. An active-low protect input stops every RAM command while it is low. Pending requests stay pending and are served once protect is released. A flag set by the external master raises a level interrupt to the local processor, which clears it again.

Top module: `shmem_arb`

## Requirements
- R1: A granted access drives `mem_en` for one command cycle. The owner's acknowledge is high in the following cycle, and only in that cycle. A read returns on `rd_data` the word most recently written at that address. During a write acknowledge `rd_data` is zero. Memory that has never been written reads as zero in the bench RAM.
- R2: Simultaneous requests are served in this order: network DMA first, then the external master, then the local processor. At most one acknowledge is high at a time. No new command is issued during an acknowledge cycle.
- R3: The private window is the address range below `code * MEM_WORDS/4`. `code` is the 3-bit size register value: 0 gives no window, 4 gives the whole memory, and 5 to 7 count as 4. The register is loaded by `priv_we` with `priv_sel` at the clock edge and is 0 after reset. A new value applies from the next cycle.
- R4: An external access whose address lies inside the window is never issued to the RAM, is never acknowledged, and leaves memory unchanged. Local processor and network accesses to the same addresses are served normally.
- R5: While `prot_n` is low, no RAM command is issued and no access is acknowledged. Requests still held when `prot_n` returns high are then served in priority order.
- R6: `tmo_irq` pulses for one cycle after `ext_req` has been sampled high on TIMEOUT_CYC consecutive clock edges without the external access being served. It pulses at most once per continuous request. The count restarts when the request is dropped or served.
- R7: `ext_flag_set` sets `flag_irq` from the next cycle. `flag_irq` then stays high until `cpu_flag_clr` clears it. If set and clear arrive in the same cycle, set wins.
- R8: After reset all acknowledges, `flag_irq`, `tmo_irq` and `rd_data` are zero, and `mem_en` stays low while there are no requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prot_n | input | 1 | Active-low memory protect; low blocks all accesses |
| cpu_req | input | 1 | Local processor request, held until acknowledged |
| cpu_we | input | 1 | Local processor write enable |
| cpu_addr | input | ADDR_W | Local processor word address |
| cpu_wdata | input | DATA_W | Local processor write data |
| cpu_ack | output | 1 | Local processor acknowledge |
| net_req | input | 1 | Network DMA request |
| net_we | input | 1 | Network DMA write enable |
| net_addr | input | ADDR_W | Network DMA word address |
| net_wdata | input | DATA_W | Network DMA write data |
| net_ack | output | 1 | Network DMA acknowledge |
| ext_req | input | 1 | External master request |
| ext_we | input | 1 | External master write enable |
| ext_addr | input | ADDR_W | External master word address |
| ext_wdata | input | DATA_W | External master write data |
| ext_ack | output | 1 | External master acknowledge |
| rd_data | output | DATA_W | Read data, valid with a read acknowledge |
| priv_we | input | 1 | Load the private-window size register |
| priv_sel | input | 3 | New private-window size code |
| ext_flag_set | input | 1 | External master sets the flag interrupt |
| cpu_flag_clr | input | 1 | Local processor clears the flag interrupt |
| flag_irq | output | 1 | Flag interrupt to the local processor |
| tmo_irq | output | 1 | One-cycle bus timeout interrupt |
| mem_en | output | 1 | RAM command strobe |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | ADDR_W | RAM address |
| mem_wdata | output | DATA_W | RAM write data |
| mem_rdata | input | DATA_W | RAM read data, one cycle after the command |

## Verification
Single requests from each master separate the basic two-cycle timing and data return from any arbitration effect. Requests raised together in one cycle from two and three masters test the priority order and the rule that the bus is held until the acknowledge. External requests placed just below and just above the window limit, for each size code including the clamped codes, check where the window boundary lies. A later local read-back of the same words shows that refused writes left memory unchanged. Stretches with protect low, long refused requests, and overlapping flag set and clear then separate blocking, timeout pulsing and flag behaviour from the normal data path.

// File: rtl/shmem_pkg.sv
package shmem_pkg;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_CPU  = 2'd1,
        SRC_NET  = 2'd2,
        SRC_EXT  = 2'd3
    } src_e;

    typedef struct packed {
        logic busy;   // acknowledge cycle in progress
        src_e owner;  // master being acknowledged
        logic rd;     // access was a read
    } arb_st_t;

endpackage

// File: rtl/shmem_window.sv
module shmem_window #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              priv_we,
    input  logic [2:0]        priv_sel,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic              ext_ok
);
    localparam int MEM_WORDS = 1 << ADDR_W;
    localparam logic [ADDR_W:0] QUART = (ADDR_W+1)'(MEM_WORDS / 4);

    logic [2:0]      code_d, code_q;
    logic [ADDR_W:0] limit;

    always_comb begin
        code_d = code_q;
        if (priv_we) begin
            code_d = priv_sel;
        end
    end

    // R3: window limit in quarter steps, codes above 4 clamp to full size
    always_comb begin
        unique case (code_q)
            3'd0:    limit = '0;
            3'd1:    limit = QUART;
            3'd2:    limit = QUART << 1;
            3'd3:    limit = (QUART << 1) + QUART;
            default: limit = QUART << 2;
        endcase
    end

    assign ext_ok = ({1'b0, ext_addr} >= limit);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
        end else begin
            code_q <= code_d;
        end
    end

endmodule

// File: rtl/shmem_prio.sv
module shmem_prio
    import shmem_pkg::*;
(
    input  logic idle,
    input  logic prot_n,
    input  logic cpu_req,
    input  logic net_req,
    input  logic ext_req,
    input  logic ext_ok,
    output src_e win
);
    // R2: network first, then external, then local processor
    always_comb begin
        win = SRC_NONE;
        if (idle && prot_n) begin
            if (net_req) begin
                win = SRC_NET;
            end else if (ext_req && ext_ok) begin
                win = SRC_EXT;
            end else if (cpu_req) begin
                win = SRC_CPU;
            end
        end
    end

endmodule

// File: rtl/shmem_tmo.sv
module shmem_tmo #(
    parameter int TIMEOUT_CYC = 1500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_req,
    input  logic ext_served,
    output logic tmo_irq
);
    localparam int CW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);
    localparam logic [CW-1:0] TOP  = CW'(TIMEOUT_CYC);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          irq;
    } tmo_st_t;

    tmo_st_t st_d, st_q;

    // R6: one pulse once the wait reaches the limit; count saturates
    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (!ext_req || ext_served) begin
            st_d.cnt = '0;
        end else begin
            st_d.irq = (st_q.cnt == LAST);
            if (st_q.cnt < TOP) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tmo_irq = st_q.irq;

endmodule

// File: rtl/shmem_flag.sv
module shmem_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic irq
);
    logic flag_d, flag_q;

    // R7: set has precedence over clear
    always_comb begin
        flag_d = flag_q;
        if (clr) begin
            flag_d = 1'b0;
        end
        if (set) begin
            flag_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign irq = flag_q;

endmodule

// File: rtl/shmem_arb.sv
module shmem_arb
    import shmem_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int DATA_W      = 16,
    parameter int TIMEOUT_CYC = 1500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prot_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ack,
    input  logic              net_req,
    input  logic              net_we,
    input  logic [ADDR_W-1:0] net_addr,
    input  logic [DATA_W-1:0] net_wdata,
    output logic              net_ack,
    input  logic              ext_req,
    input  logic              ext_we,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic [DATA_W-1:0] ext_wdata,
    output logic              ext_ack,
    output logic [DATA_W-1:0] rd_data,
    input  logic              priv_we,
    input  logic [2:0]        priv_sel,
    input  logic              ext_flag_set,
    input  logic              cpu_flag_clr,
    output logic              flag_irq,
    output logic              tmo_irq,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    arb_st_t st_d, st_q;
    src_e    win;
    logic    ext_ok;
    logic    ext_served;

    shmem_window #(.ADDR_W(ADDR_W)) window_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .priv_we  (priv_we),
        .priv_sel (priv_sel),
        .ext_addr (ext_addr),
        .ext_ok   (ext_ok)
    );

    // R4, R5: refused and protected requests never win
    shmem_prio prio_i (
        .idle    (!st_q.busy),
        .prot_n  (prot_n),
        .cpu_req (cpu_req),
        .net_req (net_req),
        .ext_req (ext_req),
        .ext_ok  (ext_ok),
        .win     (win)
    );

    assign ext_served = (win == SRC_EXT) || (st_q.busy && st_q.owner == SRC_EXT);

    shmem_tmo #(.TIMEOUT_CYC(TIMEOUT_CYC)) tmo_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_req    (ext_req),
        .ext_served (ext_served),
        .tmo_irq    (tmo_irq)
    );

    shmem_flag flag_i (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (ext_flag_set),
        .clr   (cpu_flag_clr),
        .irq   (flag_irq)
    );

    // R1: command cycle, then acknowledge cycle
    always_comb begin
        st_d      = st_q;
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        if (st_q.busy) begin
            st_d.busy  = 1'b0;
            st_d.owner = SRC_NONE;
            st_d.rd    = 1'b0;
        end else begin
            unique case (win)
                SRC_CPU: begin
                    mem_en    = 1'b1;
                    mem_we    = cpu_we;
                    mem_addr  = cpu_addr;
                    mem_wdata = cpu_wdata;
                end
                SRC_NET: begin
                    mem_en    = 1'b1;
                    mem_we    = net_we;
                    mem_addr  = net_addr;
                    mem_wdata = net_wdata;
                end
                SRC_EXT: begin
                    mem_en    = 1'b1;
                    mem_we    = ext_we;
                    mem_addr  = ext_addr;
                    mem_wdata = ext_wdata;
                end
                default: begin
                end
            endcase
            if (win != SRC_NONE) begin
                st_d.busy  = 1'b1;
                st_d.owner = win;
                st_d.rd    = !mem_we;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{busy: 1'b0, owner: SRC_NONE, rd: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cpu_ack = st_q.busy && (st_q.owner == SRC_CPU);
    assign net_ack = st_q.busy && (st_q.owner == SRC_NET);
    assign ext_ack = st_q.busy && (st_q.owner == SRC_EXT);
    assign rd_data = (st_q.busy && st_q.rd) ? mem_rdata : '0;

endmodule

// File: rtl/shmem_arb_chk.sv
module shmem_arb_chk #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              prot_n,
    input logic              net_req,
    input logic [ADDR_W-1:0] net_addr,
    input logic              cpu_ack,
    input logic              net_ack,
    input logic              ext_ack,
    input logic              ext_flag_set,
    input logic              flag_irq,
    input logic              tmo_irq,
    input logic              mem_en,
    input logic [ADDR_W-1:0] mem_addr
);
    logic any_ack;
    assign any_ack = cpu_ack || net_ack || ext_ack;

    // R2
    acks_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cpu_ack, net_ack, ext_ack}));

    // R1
    grant_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |=> any_ack);

    // R2
    ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_ack |-> !mem_en);

    // R2
    net_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (net_req && prot_n && !any_ack) |-> (mem_en && mem_addr == net_addr));

    // R5
    protect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !prot_n |-> !mem_en);

    // R7
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_flag_set |=> flag_irq);

    // R6
    tmo_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_irq |=> !tmo_irq);

endmodule

bind shmem_arb shmem_arb_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .prot_n       (prot_n),
    .net_req      (net_req),
    .net_addr     (net_addr),
    .cpu_ack      (cpu_ack),
    .net_ack      (net_ack),
    .ext_ack      (ext_ack),
    .ext_flag_set (ext_flag_set),
    .flag_irq     (flag_irq),
    .tmo_irq      (tmo_irq),
    .mem_en       (mem_en),
    .mem_addr     (mem_addr)
);

// File: tb/shmem_arb_tb.sv
module shmem_arb_tb_top;
    localparam int AW   = 6;
    localparam int DW   = 16;
    localparam int TMO  = 20;
    localparam int WRDS = 1 << AW;
    localparam int QTR  = WRDS / 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic prot_n = 1'b1;
    logic cpu_req = 0, cpu_we = 0; logic [AW-1:0] cpu_addr = '0; logic [DW-1:0] cpu_wdata = '0;
    logic net_req = 0, net_we = 0; logic [AW-1:0] net_addr = '0; logic [DW-1:0] net_wdata = '0;
    logic ext_req = 0, ext_we = 0; logic [AW-1:0] ext_addr = '0; logic [DW-1:0] ext_wdata = '0;
    logic priv_we = 0; logic [2:0] priv_sel = '0;
    logic ext_flag_set = 0, cpu_flag_clr = 0;
    logic cpu_ack, net_ack, ext_ack, flag_irq, tmo_irq, mem_en, mem_we;
    logic [DW-1:0] rd_data, mem_wdata, mem_rdata;
    logic [AW-1:0] mem_addr;

    shmem_arb #(.ADDR_W(AW), .DATA_W(DW), .TIMEOUT_CYC(TMO)) dut_i (
        .clk(clk), .rst_n(rst_n), .prot_n(prot_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack),
        .net_req(net_req), .net_we(net_we), .net_addr(net_addr), .net_wdata(net_wdata), .net_ack(net_ack),
        .ext_req(ext_req), .ext_we(ext_we), .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_ack(ext_ack),
        .rd_data(rd_data), .priv_we(priv_we), .priv_sel(priv_sel),
        .ext_flag_set(ext_flag_set), .cpu_flag_clr(cpu_flag_clr), .flag_irq(flag_irq), .tmo_irq(tmo_irq),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // simple synchronous RAM, read before write
    logic [DW-1:0] ram [WRDS];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WRDS; i++) ram[i] <= '0;
            mem_rdata <= '0;
        end else if (mem_en) begin
            mem_rdata <= ram[mem_addr];
            if (mem_we) ram[mem_addr] <= mem_wdata;
        end
    end

    int errs = 0, checks = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model, evaluated on each rising edge
    logic [DW-1:0] mem_m [WRDS];
    bit  m_busy, was_busy, served;
    int  m_owner, win, lim, m_cnt, m_priv, a;
    bit  e_cpu, e_net, e_ext, e_flag, e_tmo;
    logic [DW-1:0] e_rd;
    int  en_cnt = 0, tmo_cnt = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_owner = 0; m_cnt = 0; m_priv = 0;
            e_cpu = 0; e_net = 0; e_ext = 0; e_flag = 0; e_tmo = 0; e_rd = '0;
            for (int i = 0; i < WRDS; i++) mem_m[i] = '0;
        end else begin
            if (mem_en) en_cnt++;
            lim = ((m_priv > 4) ? 4 : m_priv) * QTR;
            was_busy = m_busy;
            served = was_busy && (m_owner == 3);
            win = 0;
            if (m_busy) begin
                m_busy = 0; m_owner = 0;
                e_cpu = 0; e_net = 0; e_ext = 0; e_rd = '0;
            end else begin
                if (prot_n) begin
                    if (net_req) win = 2;
                    else if (ext_req && int'(ext_addr) >= lim) win = 3;
                    else if (cpu_req) win = 1;
                end
                e_cpu = (win == 1); e_net = (win == 2); e_ext = (win == 3); e_rd = '0;
                if (win != 0) begin
                    m_busy = 1; m_owner = win;
                    if (win == 1) begin
                        a = int'(cpu_addr);
                        if (!cpu_we) e_rd = mem_m[a]; else mem_m[a] = cpu_wdata;
                    end else if (win == 2) begin
                        a = int'(net_addr);
                        if (!net_we) e_rd = mem_m[a]; else mem_m[a] = net_wdata;
                    end else begin
                        a = int'(ext_addr);
                        if (!ext_we) e_rd = mem_m[a]; else mem_m[a] = ext_wdata;
                    end
                end
            end
            served = served || (win == 3);
            e_tmo = 0;
            if (!ext_req || served) m_cnt = 0;
            else begin
                e_tmo = (m_cnt == TMO - 1);
                if (m_cnt < TMO) m_cnt++;
            end
            if (ext_flag_set) e_flag = 1;
            else if (cpu_flag_clr) e_flag = 0;
            if (priv_we) m_priv = int'(priv_sel);
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(cpu_ack == e_cpu, "R1 R2 R4 R5 cpu_ack", cpu_ack, e_cpu);
            chk(net_ack == e_net, "R1 R2 R5 net_ack", net_ack, e_net);
            chk(ext_ack == e_ext, "R2 R3 R4 R5 ext_ack", ext_ack, e_ext);
            chk(rd_data == e_rd,  "R1 R3 R4 rd_data", rd_data, e_rd);
            chk(tmo_irq == e_tmo, "R6 tmo_irq", tmo_irq, e_tmo);
            chk(flag_irq == e_flag, "R7 flag_irq", flag_irq, e_flag);
            if (tmo_irq) tmo_cnt++;
        end
    end

    task automatic settle(input int maxc);
        for (int i = 0; i < maxc; i++) begin
            @(negedge clk);
            if (cpu_ack) cpu_req = 0;
            if (net_ack) net_req = 0;
            if (ext_ack) ext_req = 0;
            if (!cpu_req && !net_req && !ext_req) break;
        end
    endtask

    task automatic acc(input int port, input bit we, input int ad, input int d);
        if (port == 1) begin cpu_req = 1; cpu_we = we; cpu_addr = AW'(ad); cpu_wdata = DW'(d); end
        if (port == 2) begin net_req = 1; net_we = we; net_addr = AW'(ad); net_wdata = DW'(d); end
        if (port == 3) begin ext_req = 1; ext_we = we; ext_addr = AW'(ad); ext_wdata = DW'(d); end
    endtask

    task automatic set_code(input int c);
        @(negedge clk); priv_we = 1; priv_sel = 3'(c);
        @(negedge clk); priv_we = 0;
    endtask

    // external access expected to be refused: waits past the timeout then drops
    task automatic refused(input bit we, input int ad, input int d, input string tag);
        int e0, t0;
        e0 = en_cnt; t0 = tmo_cnt;
        @(negedge clk); acc(3, we, ad, d);
        repeat (TMO + 6) @(negedge clk);
        ext_req = 0;
        @(negedge clk);
        chk(en_cnt == e0, {tag, " no RAM command"}, en_cnt - e0, 0);
        chk(tmo_cnt == t0 + 1, "R6 single timeout pulse", tmo_cnt - t0, 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1; errs++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        int e0;
        repeat (3) @(negedge clk);
        // R8: reset state
        chk(!cpu_ack && !net_ack && !ext_ack, "R8 acks in reset", {cpu_ack, net_ack, ext_ack}, 0);
        chk(!flag_irq && !tmo_irq, "R8 irqs in reset", {flag_irq, tmo_irq}, 0);
        chk(!mem_en && rd_data == '0, "R8 mem_en rd_data in reset", mem_en, 0);
        rst_n = 1;
        @(negedge clk);
        chk(!mem_en, "R8 idle mem_en", mem_en, 0);

        // R1: single accesses from each master
        acc(1, 1, 5, 16'hA5A5); settle(10);
        acc(1, 0, 5, 0); settle(10);
        acc(2, 1, 9, 16'h1234); settle(10);
        acc(3, 0, 9, 0); settle(10);
        acc(3, 1, 3, 16'h0BEE); settle(10);   // R3: code 0, no window
        acc(2, 0, 3, 0); settle(10);
        acc(1, 0, 40, 0); settle(10);         // never written

        // R2: simultaneous requests
        @(negedge clk);
        acc(1, 0, 5, 0); acc(2, 0, 9, 0); acc(3, 0, 3, 0); settle(20);
        acc(1, 1, 20, 16'h2020); acc(3, 1, 21, 16'h2121); settle(20);
        acc(1, 0, 21, 0); acc(2, 1, 22, 16'h2222); settle(20);
        acc(3, 0, 20, 0); settle(10);

        // R3, R4: window boundaries per code
        acc(1, 1, 10, 16'h7777); settle(10);
        set_code(1);
        refused(1, 10, 16'hDEAD, "R4 code1 addr10");
        refused(0, QTR - 1, 0, "R3 code1 just inside");
        acc(3, 0, QTR, 0); settle(10);        // first word outside
        acc(1, 0, 10, 0); settle(10);         // R4: unchanged, local access allowed
        acc(2, 1, 11, 16'h5151); settle(10);  // R4: network into window
        set_code(3);
        refused(0, 3 * QTR - 1, 0, "R3 code3 just inside");
        acc(3, 1, 3 * QTR, 16'h3030); settle(10);
        set_code(7);
        refused(1, WRDS - 1, 16'hFFFF, "R3 code7 clamps to full");
        set_code(4);
        refused(0, WRDS - 1, 0, "R3 code4 full");
        acc(1, 0, WRDS - 1, 0); settle(10);
        set_code(2);
        acc(3, 0, 2 * QTR, 0); settle(10);
        set_code(0);
        acc(3, 0, 10, 0); settle(10);

        // R5: protect blocks all accesses
        @(negedge clk); prot_n = 0;
        e0 = en_cnt;
        acc(1, 1, 30, 16'hCAFE); acc(2, 0, 5, 0);
        repeat (10) @(negedge clk);
        chk(en_cnt == e0, "R5 no RAM command while protected", en_cnt - e0, 0);
        chk(!cpu_ack && !net_ack, "R5 no ack while protected", {cpu_ack, net_ack}, 0);
        prot_n = 1;
        settle(20);
        acc(3, 0, 30, 0); settle(10);

        // R6: external waiting behind others is not a timeout when served in time
        acc(2, 0, 1, 0); acc(3, 0, 2, 0); settle(20);

        // R7: flag set, hold, clear, simultaneous set and clear
        @(negedge clk); ext_flag_set = 1;
        @(negedge clk); ext_flag_set = 0;
        repeat (4) @(negedge clk);
        chk(flag_irq, "R7 flag held", flag_irq, 1);
        cpu_flag_clr = 1;
        @(negedge clk); cpu_flag_clr = 0;
        @(negedge clk);
        chk(!flag_irq, "R7 flag cleared", flag_irq, 0);
        ext_flag_set = 1; cpu_flag_clr = 1;
        @(negedge clk); ext_flag_set = 0; cpu_flag_clr = 0;
        @(negedge clk);
        chk(flag_irq, "R7 set wins", flag_irq, 1);

        repeat (3) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule